// File: doc/BRIEF.md
# Digital Lock Detector with Output Mute

This block decides whether a phase-locked loop has settled. It samples the reference pulse and the feedback-divider pulse with a fast sampling clock. For each pair of matching rising edges it counts the sampling ticks between them, whichever edge comes first. A reference cycle counts as good when the edge gap is shorter than a programmable window. The lock flag rises once enough good cycles have arrived in a row. A single bad cycle drops it again.

The lock flag also drives an output gate. When the mute option is set, the RF output enable stays low until lock has been declared. When the mute option is clear, the enable depends only on power-down. Power-down clears the detector and holds the output enable low. The phase-frequency detector and the charge pump sit outside this block.

Top module: `pll_lock_detect`

## Requirements
- R1: The phase error is the number of sampling ticks between a reference rising edge and the matching feedback rising edge, whichever of the two leads. A cycle is good when this error is below WINDOW_TICKS (default 8), so 7 ticks is good and 0 ticks (both edges together) is good.
- R2: A cycle is bad when the error reaches WINDOW_TICKS, or when the leading input shows a second rising edge before the other input has shown one.
- R3: With prec_sel = 0, locked rises after 3 consecutive good cycles and not after 2.
- R4: With prec_sel = 1, locked rises after 5 consecutive good cycles and not after 4.
- R5: A bad cycle clears the run of good cycles and drops locked on the next clock. Lock then needs a complete new run.
- R6: While pwr_down = 1, the run count, any pending measurement and locked are cleared, and out_en is 0. Once pwr_down falls, locked stays 0 until a new run completes.
- R7: With mute_en = 1, out_en is 0 whenever locked is 0, and out_en is 1 when locked is 1 and pwr_down is 0.
- R8: With mute_en = 0, out_en equals the inverse of pwr_down, whatever the lock state.
- R9: After reset, locked is 0, and out_en is 0 if mute_en = 1 or 1 if mute_en = 0 (with pwr_down = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock; sets the unit of phase error |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference pulse; a rising edge marks each reference cycle |
| fb_pulse | input | 1 | Feedback divider output pulse |
| prec_sel | input | 1 | Precision select: 0 needs 3 good cycles, 1 needs 5 good cycles |
| mute_en | input | 1 | 1 holds out_en low until lock is declared |
| pwr_down | input | 1 | 1 clears the detector and disables the output |
| locked | output | 1 | Lock flag |
| out_en | output | 1 | RF output enable |

## Verification
The assertions check the output gating on every cycle. These checks cover power-down forcing out_en low, mute holding out_en low while unlocked, and out_en following power-down when mute is off. On every cycle the assertions also check that power-down and bad verdicts clear locked on the next clock, that locked only rises after a good verdict, and that the meter never issues a good and a bad verdict in the same cycle. Only the bench scenarios can show the exact count of good cycles needed for each precision setting, the tick boundary of the window for both lead orders, and the handling of a repeated edge.

// File: rtl/ld_pkg.sv
package ld_pkg;

   // Verdict produced once per paired edge measurement
   typedef struct packed {
      logic good;
      logic bad;
   } verdict_t;

   // Width of a counter that must hold values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/ld_edge_sense.sv
module ld_edge_sense #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o
);

   logic sampled;
   logic sampled_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = sig_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2+1-1:0], sig_i} ;
         end
         assign sampled = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sampled_q <= 1'b0;
      else        sampled_q <= sampled;
   end

   assign rise_o = sampled & ~sampled_q;

endmodule

// File: rtl/ld_phase_meter.sv
module ld_phase_meter
   import ld_pkg::*;
#(
   parameter int unsigned WINDOW_TICKS = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  logic     ref_rise_i,
   input  logic     fb_rise_i,
   output verdict_t verdict_o
);

   localparam int unsigned TW = cnt_width(WINDOW_TICKS);
   localparam logic [TW-1:0] WIN = TW'(WINDOW_TICKS);
   localparam logic [TW-1:0] ONE = TW'(1);

   logic          waiting;
   logic          lead_ref;
   logic [TW-1:0] gap;
   logic          trail_seen;
   logic          lead_again;

   always_comb begin
      trail_seen = lead_ref ? fb_rise_i  : ref_rise_i;
      lead_again = lead_ref ? ref_rise_i : fb_rise_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting   <= 1'b0;
         lead_ref  <= 1'b0;
         gap       <= '0;
         verdict_o <= '0;
      end else begin
         verdict_o <= '0;
         if (clr_i) begin
            waiting <= 1'b0;
            gap     <= '0;
         end else if (!waiting) begin
            if (ref_rise_i && fb_rise_i) begin
               verdict_o.good <= 1'b1;
            end else if (ref_rise_i || fb_rise_i) begin
               waiting  <= 1'b1;
               lead_ref <= ref_rise_i;
               gap      <= ONE;
            end
         end else if (trail_seen) begin
            if (gap < WIN) verdict_o.good <= 1'b1;
            else           verdict_o.bad  <= 1'b1;
            if (lead_again) gap <= ONE;
            else            waiting <= 1'b0;
         end else if (lead_again) begin
            verdict_o.bad <= 1'b1;
            gap           <= ONE;
         end else if (gap >= WIN) begin
            verdict_o.bad <= 1'b1;
            waiting       <= 1'b0;
         end else begin
            gap <= gap + ONE;
         end
      end
   end

endmodule

// File: rtl/ld_lock_counter.sv
module ld_lock_counter
   import ld_pkg::*;
#(
   parameter int unsigned LOCK_LO = 3,
   parameter int unsigned LOCK_HI = 5
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  logic     prec_i,
   input  verdict_t verdict_i,
   output logic     locked_o
);

   localparam int unsigned CW = cnt_width(LOCK_HI);
   localparam logic [CW-1:0] LO_V = CW'(LOCK_LO);
   localparam logic [CW-1:0] HI_V = CW'(LOCK_HI);

   logic [CW-1:0] run;
   logic [CW-1:0] run_next;
   logic [CW-1:0] need;

   always_comb begin
      need     = prec_i ? HI_V : LO_V;
      run_next = (run == HI_V) ? run : run + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= '0;
         locked_o <= 1'b0;
      end else if (clr_i || verdict_i.bad) begin
         run      <= '0;
         locked_o <= 1'b0;
      end else if (verdict_i.good) begin
         run <= run_next;
         if (run_next >= need) locked_o <= 1'b1;
      end
   end

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
   import ld_pkg::*;
#(
   parameter int unsigned WINDOW_TICKS = 8,
   parameter int unsigned LOCK_LO     = 3,
   parameter int unsigned LOCK_HI     = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_pulse,
   input  logic fb_pulse,
   input  logic prec_sel,
   input  logic mute_en,
   input  logic pwr_down,
   output logic locked,
   output logic out_en
);

   generate
      if (WINDOW_TICKS < 1) begin : g_bad_win
         $error("WINDOW_TICKS must be at least 1");
      end
      if (LOCK_LO < 1 || LOCK_HI < LOCK_LO) begin : g_bad_lock
         $error("LOCK_LO must be at least 1 and no larger than LOCK_HI");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic     ref_rise;
   logic     fb_rise;
   verdict_t verdict;
   logic     v_good;
   logic     v_bad;

   ld_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(ref_pulse), .rise_o(ref_rise)
   );

   ld_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(fb_pulse), .rise_o(fb_rise)
   );

   ld_phase_meter #(.WINDOW_TICKS(WINDOW_TICKS)) u_meter (
      .clk(clk), .rst_n(rst_n), .clr_i(pwr_down),
      .ref_rise_i(ref_rise), .fb_rise_i(fb_rise), .verdict_o(verdict)
   );

   ld_lock_counter #(.LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)) u_count (
      .clk(clk), .rst_n(rst_n), .clr_i(pwr_down), .prec_i(prec_sel),
      .verdict_i(verdict), .locked_o(locked)
   );

   assign v_good = verdict.good;
   assign v_bad  = verdict.bad;

   // Output gate: power-down always wins, mute waits for lock
   assign out_en = ~pwr_down & (~mute_en | locked);

endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_down,
   input logic mute_en,
   input logic locked,
   input logic out_en,
   input logic v_good,
   input logic v_bad
);

   // R1 and R2: a measurement yields at most one verdict
   a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(v_good && v_bad));

   // R5: a bad verdict drops lock on the next clock
   a_r5_bad_drops: assert property (@(posedge clk) disable iff (!rst_n)
      v_bad |=> !locked);

   // R3 and R4: lock only rises right after a good verdict
   a_r3_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(v_good));

   // R6: power-down clears lock and blocks the output
   a_r6_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !locked);
   a_r6_pd_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !out_en);

   // R7: muted output stays off while unlocked
   a_r7_mute_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_en && !locked) |-> !out_en);

   // R8: unmuted output follows power-down only
   a_r8_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
      (!mute_en && !pwr_down) |-> out_en);

endmodule

bind pll_lock_detect pll_lock_detect_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .mute_en(mute_en),
   .locked(locked), .out_en(out_en), .v_good(v_good), .v_bad(v_bad)
);

// File: tb/test_pll_lock_detect.sv
module test_pll_lock_detect;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_pulse = 1'b0;
   logic fb_pulse = 1'b0;
   logic prec_sel = 1'b0;
   logic mute_en = 1'b1;
   logic pwr_down = 1'b0;
   logic locked;
   logic out_en;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   pll_lock_detect i_pll_lock_detect (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
      .prec_sel(prec_sel), .mute_en(mute_en), .pwr_down(pwr_down),
      .locked(locked), .out_en(out_en)
   );

   typedef struct packed {
      logic prec;
      logic mute;
      int   off;
      int   frames;
      logic exp_lk;
      logic exp_oe;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1,  7,  2, 1'b0, 1'b0},   // R3 two good, window edge 7
      '{1'b0, 1'b1,  7,  3, 1'b1, 1'b1},   // R3 three good
      '{1'b1, 1'b1, -7,  4, 1'b0, 1'b0},   // R4 four good, fb leads
      '{1'b1, 1'b1, -7,  5, 1'b1, 1'b1},   // R4 five good
      '{1'b0, 1'b0,  0,  1, 1'b0, 1'b1},   // R8 unmuted while unlocked
      '{1'b0, 1'b1,  8,  6, 1'b0, 1'b0},   // R1 error equal window is bad
      '{1'b1, 1'b0, -8,  6, 1'b0, 1'b1},   // R1 fb leads by window
      '{1'b0, 1'b1,  3, 10, 1'b1, 1'b1},   // R7 long good run
      '{1'b1, 1'b1, -3,  3, 1'b0, 1'b0},   // R4 short run muted
      '{1'b0, 1'b0, 20,  6, 1'b0, 1'b1}    // R2 far edges time out
   };

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One 40-clock reference frame; off>0 fb lags ref, off<0 fb leads
   task automatic run_frame(input int off, input bit dbl_ref);
      int rs;
      int fs;
      if (off >= 0) begin rs = 5; fs = 5 + off; end
      else          begin fs = 5; rs = 5 - off; end
      for (int s = 0; s < 40; s++) begin
         @(negedge clk);
         ref_pulse = (s == rs) || (dbl_ref && s == 2);
         fb_pulse  = (s == fs);
      end
   endtask

   task automatic clear_pd();
      @(negedge clk);
      pwr_down = 1'b1;
      idle(2);
      pwr_down = 1'b0;
      idle(1);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R9 reset state
      check("R9 locked after reset", locked, 1'b0);
      check("R9 out_en muted after reset", out_en, 1'b0);
      mute_en = 1'b0;
      idle(1);
      check("R9 out_en unmuted after reset", out_en, 1'b1);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         clear_pd();
         prec_sel = VECS[v].prec;
         mute_en  = VECS[v].mute;
         for (int f = 0; f < VECS[v].frames; f++) run_frame(VECS[v].off, 1'b0);
         idle(4);
         check($sformatf("R3/R4 vector %0d locked", v), locked, VECS[v].exp_lk);
         check($sformatf("R7/R8 vector %0d out_en", v), out_en, VECS[v].exp_oe);
      end

      // R5: bad cycle drops lock and restarts the run
      clear_pd();
      prec_sel = 1'b0;
      mute_en  = 1'b1;
      for (int f = 0; f < 3; f++) run_frame(2, 1'b0);
      check("R5 locked before bad cycle", locked, 1'b1);
      run_frame(12, 1'b0);
      check("R5 lock dropped by bad cycle", locked, 1'b0);
      check("R7 out_en off after drop", out_en, 1'b0);
      for (int f = 0; f < 2; f++) run_frame(2, 1'b0);
      check("R5 two good after bad not locked", locked, 1'b0);
      run_frame(2, 1'b0);
      check("R5 relock after full run", locked, 1'b1);

      // R2: repeated leading edge is a bad cycle
      run_frame(2, 1'b1);
      check("R2 repeated ref edge drops lock", locked, 1'b0);
      for (int f = 0; f < 2; f++) run_frame(2, 1'b0);
      check("R2 run restarted after repeat", locked, 1'b1);

      // R6: power-down clears lock and output
      mute_en = 1'b0;
      @(negedge clk);
      pwr_down = 1'b1;
      idle(2);
      check("R6 locked cleared in power-down", locked, 1'b0);
      check("R6 out_en off in power-down", out_en, 1'b0);
      pwr_down = 1'b0;
      idle(2);
      check("R6 locked stays 0 after power-down", locked, 1'b0);
      check("R8 out_en back after power-down", out_en, 1'b1);
      mute_en = 1'b1;
      idle(1);
      check("R7 muted out_en after power-down", out_en, 1'b0);

      // R6: power-down in the middle of a measurement discards it
      @(negedge clk);
      ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0;
      idle(2);
      pwr_down = 1'b1;
      idle(2);
      pwr_down = 1'b0;
      for (int f = 0; f < 2; f++) run_frame(1, 1'b0);
      check("R6 pending edge discarded, two good", locked, 1'b0);
      run_frame(0, 1'b0);
      check("R1 coincident edges good, lock on third", locked, 1'b1);

      idle(5);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule